// File: doc/BRIEF.md
# Linked Threshold Event Counter Pair

This block holds two 64-bit event accumulators that work side by side: a primary counter (position 0) and a secondary counter (position 1). On every clock, each counter receives an unsigned per-cycle event amount. It compares that amount with its own threshold using a 3-bit mode code, and then adds the amount, adds one, or adds nothing. Software-side logic preloads either counter through a dedicated write port.

The secondary counter also has a 2-bit link code. With this code it can take the primary counter's event amount of the same cycle in place of its own. The partner's amount can be chosen either when the secondary comparison fails or when it passes. The comparison itself always uses the secondary counter's own amount and threshold. The link code on the primary counter has no effect.

Both counters update on the same edge from the event amounts present in that cycle. They wrap modulo 2^64. Reset is asynchronous and active-low, and its release is synchronised inside the block over two clock edges.

Top module: `lc_pair`

## Requirements
- R1: While reset is held, and until the first update after its release, both counts read zero.
- R2: When a counter's write enable is high at a clock edge, that counter takes the write data on that edge, whatever its event amount and configuration.
- R3: Without a write, the primary counter compares its amount V with its threshold T as unsigned numbers. Mode bits [2:1] pick the test: 00 means V != T, 01 means V == T, 10 means V >= T, 11 means V < T. When the test holds, mode bit 0 = 1 adds one and mode bit 0 = 0 adds V; when it fails, nothing is added. Its link input has no effect.
- R4: With mode 000 and threshold 0, a counter adds its full event amount every cycle, including zero.
- R5: With link code 00, the secondary counter follows exactly the rule of R3 using its own amount, threshold and mode.
- R6: With link code 01, the secondary counter adds the primary's same-cycle amount when its own test fails. When its own test passes, it adds one or its own amount, as mode bit 0 directs.
- R7: With link code 10 and an even mode (000, 010, 100, 110), the secondary counter adds the primary's same-cycle amount when its own test passes. It adds nothing when the test fails.
- R8: With link code 11, or with link code 10 and an odd mode, the secondary counter adds nothing.
- R9: Both counters wrap modulo 2^64 on overflow, and both update on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_val_p | input | VAL_W | Primary counter per-cycle event amount |
| ev_val_s | input | VAL_W | Secondary counter per-cycle event amount |
| thr_p | input | TH_W | Primary threshold |
| thr_s | input | TH_W | Secondary threshold |
| mode_p | input | 3 | Primary threshold mode |
| mode_s | input | 3 | Secondary threshold mode |
| link_p | input | 2 | Link code at primary position (no effect) |
| link_s | input | 2 | Secondary link code |
| wr_en_p | input | 1 | Primary counter load enable |
| wr_en_s | input | 1 | Secondary counter load enable |
| wr_data_p | input | CNT_W | Primary load value |
| wr_data_s | input | CNT_W | Secondary load value |
| count_p | output | CNT_W | Primary count |
| count_s | output | CNT_W | Secondary count |

## Verification
A wrong increment choice shows at the count outputs one edge after the cycle that caused it. Because the counters never forget, the error then stays in the count until the next load. Each trial therefore preloads a known base and checks the count after exactly one counting edge, so a fault is pinned to a single combination of link code, mode, threshold and amounts. The sweep covers every link code and every mode. Its amounts sit below, at and above the threshold, and its thresholds include one beyond the amount range. Bases near the top of the count range expose a lost carry or a missing wrap.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    CMP_NE = 2'b00,
    CMP_EQ = 2'b01,
    CMP_GE = 2'b10,
    CMP_LT = 2'b11
  } cmp_kind_t;

  typedef enum logic [1:0] {
    LINK_OFF  = 2'b00,
    LINK_FAIL = 2'b01,
    LINK_PASS = 2'b10,
    LINK_RSVD = 2'b11
  } link_t;

  localparam int unsigned NUM_CNT = 2;

endpackage

// File: rtl/lc_compare.sv
module lc_compare #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned TH_W  = 12
) (
  input  logic [VAL_W-1:0] val,
  input  logic [TH_W-1:0]  thr,
  input  logic [1:0]       kind,
  output logic             hit
);
  import lc_pkg::*;

  localparam int unsigned CMP_W = (VAL_W > TH_W) ? VAL_W : TH_W;

  logic [CMP_W-1:0] a_ext;
  logic [CMP_W-1:0] b_ext;
  cmp_kind_t        kind_e;

  always_comb begin
    a_ext  = CMP_W'(val);
    b_ext  = CMP_W'(thr);
    kind_e = cmp_kind_t'(kind);
    unique case (kind_e)
      CMP_NE:  hit = (a_ext != b_ext);
      CMP_EQ:  hit = (a_ext == b_ext);
      CMP_GE:  hit = (a_ext >= b_ext);
      default: hit = (a_ext <  b_ext);
    endcase
  end

endmodule

// File: rtl/lc_incr_sel.sv
module lc_incr_sel #(
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned CNT_W  = 64,
  parameter bit          IS_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [1:0]       link,
  input  logic             hit,
  input  logic [VAL_W-1:0] own_val,
  input  logic [VAL_W-1:0] partner_val,
  output logic [CNT_W-1:0] inc
);
  import lc_pkg::*;

  link_t            link_eff;
  logic [CNT_W-1:0] own_ext;
  logic [CNT_W-1:0] partner_ext;
  logic [CNT_W-1:0] own_amt;

  always_comb begin
    link_eff    = link_t'(IS_ODD ? link : 2'b00);
    own_ext     = CNT_W'(own_val);
    partner_ext = CNT_W'(partner_val);
    own_amt     = mode[0] ? CNT_W'(1) : own_ext;
    unique case (link_eff)
      LINK_OFF:  inc = hit ? own_amt : '0;
      LINK_FAIL: inc = hit ? own_amt : partner_ext;
      LINK_PASS: inc = (hit && !mode[0]) ? partner_ext : '0;
      default:   inc = '0;
    endcase
  end

  AST_RSVD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_ODD && link == 2'b11) |-> (inc == '0)); // R8

  AST_PASS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_ODD && link == 2'b10 && !hit) |-> (inc == '0)); // R7

  AST_FAIL_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_ODD && link == 2'b01 && !hit) |-> (inc == CNT_W'(partner_val))); // R6

  AST_PRIMARY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_ODD && !hit) |-> (inc == '0)); // R3

endmodule

// File: rtl/lc_counter.sv
module lc_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = wr_en || (inc != '0);
    cnt_d  = wr_en ? wr_data : (cnt_q + inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data))); // R2

  AST_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (count == $past(count) + $past(inc))); // R9

endmodule

// File: rtl/lc_pair.sv
module lc_pair #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned TH_W  = 12,
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] ev_val_p,
  input  logic [VAL_W-1:0] ev_val_s,
  input  logic [TH_W-1:0]  thr_p,
  input  logic [TH_W-1:0]  thr_s,
  input  logic [2:0]       mode_p,
  input  logic [2:0]       mode_s,
  input  logic [1:0]       link_p,
  input  logic [1:0]       link_s,
  input  logic             wr_en_p,
  input  logic             wr_en_s,
  input  logic [CNT_W-1:0] wr_data_p,
  input  logic [CNT_W-1:0] wr_data_s,
  output logic [CNT_W-1:0] count_p,
  output logic [CNT_W-1:0] count_s
);
  import lc_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic [VAL_W-1:0] ev_a   [NUM_CNT];
  logic [TH_W-1:0]  thr_a  [NUM_CNT];
  logic [2:0]       mode_a [NUM_CNT];
  logic [1:0]       link_a [NUM_CNT];
  logic             wen_a  [NUM_CNT];
  logic [CNT_W-1:0] wdat_a [NUM_CNT];
  logic [CNT_W-1:0] cnt_a  [NUM_CNT];

  always_comb begin
    ev_a[0]   = ev_val_p;   ev_a[1]   = ev_val_s;
    thr_a[0]  = thr_p;      thr_a[1]  = thr_s;
    mode_a[0] = mode_p;     mode_a[1] = mode_s;
    link_a[0] = link_p;     link_a[1] = link_s;
    wen_a[0]  = wr_en_p;    wen_a[1]  = wr_en_s;
    wdat_a[0] = wr_data_p;  wdat_a[1] = wr_data_s;
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    localparam bit ODD = (gi % 2) == 1;

    logic             hit;
    logic [CNT_W-1:0] inc;
    logic [VAL_W-1:0] partner;

    assign partner = ODD ? ev_a[gi-(ODD ? 1 : 0)] : '0;

    lc_compare #(.VAL_W(VAL_W), .TH_W(TH_W)) u_cmp (
      .val  (ev_a[gi]),
      .thr  (thr_a[gi]),
      .kind (mode_a[gi][2:1]),
      .hit  (hit)
    );

    lc_incr_sel #(.VAL_W(VAL_W), .CNT_W(CNT_W), .IS_ODD(ODD)) u_sel (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .mode        (mode_a[gi]),
      .link        (link_a[gi]),
      .hit         (hit),
      .own_val     (ev_a[gi]),
      .partner_val (partner),
      .inc         (inc)
    );

    lc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wen_a[gi]),
      .wr_data (wdat_a[gi]),
      .inc     (inc),
      .count   (cnt_a[gi])
    );
  end

  assign count_p = cnt_a[0];
  assign count_s = cnt_a[1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (!rst_sync_n) |-> (count_p == '0 && count_s == '0)); // R1

endmodule

// File: tb/sim_lc_pair.sv
module sim_lc_pair;

  localparam int unsigned VAL_W  = 8;
  localparam int unsigned TH_W   = 12;
  localparam int unsigned CNT_W  = 64;
  localparam time         CLK_PER = 10ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [VAL_W-1:0] ev_val_p, ev_val_s;
  logic [TH_W-1:0]  thr_p, thr_s;
  logic [2:0]       mode_p, mode_s;
  logic [1:0]       link_p, link_s;
  logic             wr_en_p, wr_en_s;
  logic [CNT_W-1:0] wr_data_p, wr_data_s;
  logic [CNT_W-1:0] count_p, count_s;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  lc_pair #(.VAL_W(VAL_W), .TH_W(TH_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_val_p(ev_val_p), .ev_val_s(ev_val_s),
    .thr_p(thr_p), .thr_s(thr_s),
    .mode_p(mode_p), .mode_s(mode_s),
    .link_p(link_p), .link_s(link_s),
    .wr_en_p(wr_en_p), .wr_en_s(wr_en_s),
    .wr_data_p(wr_data_p), .wr_data_s(wr_data_s),
    .count_p(count_p), .count_s(count_s)
  );

  task automatic check(input string tag, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected per-cycle addition, taken from the requirement text.
  function automatic logic [CNT_W-1:0] exp_inc(input logic [2:0] mode,
      input int thr, input int own, input int partner, input logic [1:0] link);
    bit          pass;
    logic [CNT_W-1:0] amt;
    case (mode[2:1])
      2'b00:   pass = (own != thr);
      2'b01:   pass = (own == thr);
      2'b10:   pass = (own >= thr);
      default: pass = (own <  thr);
    endcase
    amt = mode[0] ? 64'd1 : 64'(own);
    case (link)
      2'b00:   return pass ? amt : 64'd0;
      2'b01:   return pass ? amt : 64'(partner);
      2'b10:   return (!mode[0] && pass) ? 64'(partner) : 64'd0;
      default: return 64'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int thr_list [4] = '{0, 5, 200, 300};
    int own_list [5] = '{0, 4, 5, 6, 255};
    int trial = 0;

    rst_n = 1'b0;
    ev_val_p = '0; ev_val_s = '0; thr_p = '0; thr_s = '0;
    mode_p = '0; mode_s = '0; link_p = '0; link_s = '0;
    wr_en_p = 1'b0; wr_en_s = 1'b0; wr_data_p = '0; wr_data_s = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset primary", count_p, '0);
    check("R1 reset secondary", count_s, '0);
    ev_val_p = 8'd9; ev_val_s = 8'd9;
    @(posedge clk);
    @(negedge clk);
    check("R1 held primary", count_p, '0);
    check("R1 held secondary", count_s, '0);
    rst_n = 1'b1;
    ev_val_p = '0; ev_val_s = '0;
    repeat (3) @(negedge clk);
    check("R1 after release primary", count_p, '0);
    check("R1 after release secondary", count_s, '0);

    for (int lk = 0; lk < 4; lk++) begin
      for (int md = 0; md < 8; md++) begin
        for (int ti = 0; ti < 4; ti++) begin
          for (int oi = 0; oi < 5; oi++) begin
            logic [CNT_W-1:0] base_p, base_s, ep, es;
            int own   = own_list[oi];
            int thr   = thr_list[ti];
            int part  = (own * 7 + 3 + md) % 256;
            base_p = (trial % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FFC0 + 64'(trial % 16)
                                      : 64'h0123_4567_0000_0000 + 64'(trial);
            base_s = base_p ^ 64'h0000_0F00_0000_0000;

            // load cycle with live events and config: load must win (R2)
            mode_p = 3'(md); mode_s = 3'(md);
            thr_p = 12'(thr); thr_s = 12'(thr);
            link_p = 2'(lk); link_s = 2'(lk);
            ev_val_p = 8'(part); ev_val_s = 8'(own);
            wr_en_p = 1'b1; wr_en_s = 1'b1;
            wr_data_p = base_p; wr_data_s = base_s;
            @(posedge clk);
            @(negedge clk);
            check("R2 load primary", count_p, base_p);
            check("R2 load secondary", count_s, base_s);

            // one counting edge
            wr_en_p = 1'b0; wr_en_s = 1'b0;
            @(posedge clk);
            @(negedge clk);
            // primary uses its own amount 'part' with the same mode and
            // threshold; its link input has no effect (R3, R4)
            ep = base_p + exp_inc(3'(md), thr, part, 0, 2'b00);
            // secondary: R5 (lk=0), R6 (lk=1), R7/R8 (lk=2,3); R9 wrap
            es = base_s + exp_inc(3'(md), thr, own, part, 2'(lk));
            check($sformatf("R3 primary lk=%0d md=%0d th=%0d", lk, md, thr),
                  count_p, ep);
            case (lk)
              0: check($sformatf("R5 secondary md=%0d th=%0d v=%0d", md, thr, own), count_s, es);
              1: check($sformatf("R6 secondary md=%0d th=%0d v=%0d", md, thr, own), count_s, es);
              2: check($sformatf("R7 secondary md=%0d th=%0d v=%0d", md, thr, own), count_s, es);
              default: check($sformatf("R8 secondary md=%0d th=%0d v=%0d", md, thr, own), count_s, es);
            endcase
            trial++;
          end
        end
      end
    end

    // R4: disabled threshold adds the full amount over several cycles
    mode_p = 3'd0; mode_s = 3'd0; thr_p = '0; thr_s = '0;
    link_p = 2'd0; link_s = 2'd0;
    wr_en_p = 1'b1; wr_en_s = 1'b1; wr_data_p = '0; wr_data_s = '0;
    @(posedge clk);
    @(negedge clk);
    wr_en_p = 1'b0; wr_en_s = 1'b0;
    ev_val_p = 8'd17; ev_val_s = 8'd0;
    @(posedge clk);
    @(negedge clk);
    ev_val_p = 8'd0; ev_val_s = 8'd200;
    @(posedge clk);
    @(negedge clk);
    check("R4 disabled primary sum", count_p, 64'd17);
    check("R4 disabled secondary sum", count_s, 64'd200);

    // R9: exact wrap to small value
    wr_en_p = 1'b1; wr_en_s = 1'b1;
    wr_data_p = 64'hFFFF_FFFF_FFFF_FFFF; wr_data_s = 64'hFFFF_FFFF_FFFF_FFFE;
    @(posedge clk);
    @(negedge clk);
    wr_en_p = 1'b0; wr_en_s = 1'b0;
    ev_val_p = 8'd3; ev_val_s = 8'd5;
    @(posedge clk);
    @(negedge clk);
    check("R9 wrap primary", count_p, 64'd2);
    check("R9 wrap secondary", count_s, 64'd3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule